// File: doc/BRIEF.md
# RTC Alarm and Square-Wave Controller

This block holds the control logic that sits around a real-time clock counter. It watches the running seconds count and compares it with a programmable alarm value. It keeps two sticky alarm flags. One flag is for the time-of-day match and the other is for a subsecond timer reload. Each flag is masked by its own enable bit. The masked flags form a wake request, and the same masked flags, gated by a global interrupt allow, form an interrupt request.

The block also drives a shared pin with a square wave. The wave comes from either a slow tap or a fast tap of the clock chain. The block tells the pin multiplexer which function owns the pin: the square wave, a debug data output, or plain I/O. Two control fields, the clock run enable and the trim value, are guarded by an unlock bit, so a stray write cannot stop or detune the clock.

Software reaches the block through a simple write port with four addresses:
- 0: control
- 1: alarm low half
- 2: alarm high bits
- 3: trim

The seconds counter itself and the trim arithmetic live outside this block.

Top module: `rtc_alarm_ctl`

## Requirements
- R1: The time-of-day flag sets one cycle after the cycle in which `sec_count` first equals the alarm value. The alarm value is {alarm-high register bits [3:0], alarm-low register bits [15:0]}. The flag is not set again while the count stays equal, even after it has been cleared.
- R2: The subsecond flag sets on the clock edge that samples `subsec_reload` high.
- R3: Both flags are sticky. Writing 1 to control bit 6 clears the time-of-day flag, and writing 1 to control bit 7 clears the subsecond flag. Writing 0 to either bit leaves the flag unchanged.
- R4: If a hardware set and a software clear of a flag fall on the same edge, the flag ends up set.
- R5: `irq` is high exactly when `gie` is 1 and a flag is set whose enable is 1. Control bit 0 enables the time-of-day flag and bit 1 enables the subsecond flag.
- R6: `wake` is high exactly when a flag is set whose enable is 1. It does not depend on `gie`.
- R7: When control bit 2 (square-wave enable) is 1, `sqw_oe` is 1. In that case `sqw_out` follows `tap_fast` if control bit 3 is 1, and `tap_slow` if bit 3 is 0. When bit 2 is 0, `sqw_oe` and `sqw_out` are both 0, whatever bit 3 holds.
- R8: `pin_sel` is 2'b10 (square wave) when the square-wave enable is 1. Otherwise it is 2'b01 (debug output) when `dbg_en` is 1, and 2'b00 (plain I/O) in all other cases.
- R9: A write changes `run_en` (control bit 5) or `trim` (address 3, bits [7:0]) only if the unlock bit (control bit 4) was already 1 before that write. All other control bits are always writable.
- R10: After reset, every control bit, the alarm value, `trim`, both flags, `irq`, `wake`, `sqw_oe` and `pin_sel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_count | input | 20 | Running seconds count |
| subsec_reload | input | 1 | Strobe: the subsecond timer was reloaded |
| tap_slow | input | 1 | Slow clock tap (1 Hz) |
| tap_fast | input | 1 | Fast clock tap (512 Hz) |
| dbg_en | input | 1 | The debug data output asks for the shared pin |
| gie | input | 1 | Global interrupt allow |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| tod_flag | output | 1 | Sticky time-of-day alarm flag |
| sub_flag | output | 1 | Sticky subsecond alarm flag |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request for stop exit and clock switchback |
| sqw_out | output | 1 | Square-wave pin data |
| sqw_oe | output | 1 | Square-wave pin drive enable |
| pin_sel | output | 2 | Shared pin function select |
| run_en | output | 1 | Protected clock run enable |
| trim | output | 8 | Protected trim value |

## Verification
The alarm compare is driven with a seconds count held on the alarm value across several cycles, and a flag clear is issued during that hold. This separates entry detection from a level compare. The count then leaves the alarm value and comes back, which shows that a new entry sets the flag again. Random traffic then mixes reload strobes, clear writes, protected writes with the unlock bit on and off, and random tap, `gie` and `dbg_en` levels, so the flag, interrupt, wake and pin paths are each compared with a bench model under many combinations. Directed cases cover a set and a clear on the same edge, an unlock and a run enable in the same write, and a disabled square wave with the fast select still set.

// File: rtl/rtc_alarm_pkg.sv
`timescale 1ns/1ps
package rtc_alarm_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_ALM_LO = 2'd1;
  localparam logic [ADDR_W-1:0] A_ALM_HI = 2'd2;
  localparam logic [ADDR_W-1:0] A_TRIM   = 2'd3;

  localparam int B_TOD_IE  = 0;
  localparam int B_SUB_IE  = 1;
  localparam int B_SQ_EN   = 2;
  localparam int B_SQ_FAST = 3;
  localparam int B_UNLOCK  = 4;
  localparam int B_RUN     = 5;
  localparam int B_CLR_TOD = 6;
  localparam int B_CLR_SUB = 7;

  localparam int N_ALARM = 2;
  localparam int IDX_TOD = 0;
  localparam int IDX_SUB = 1;

  typedef enum logic [1:0] {
    PIN_GPIO = 2'b00,
    PIN_DBG  = 2'b01,
    PIN_SQW  = 2'b10
  } pin_sel_e;

  typedef struct packed {
    logic run;
    logic unlock;
    logic sq_fast;
    logic sq_en;
    logic sub_ie;
    logic tod_ie;
  } ctrl_t;
endpackage

// File: rtl/rtc_ctl_regs.sv
`timescale 1ns/1ps
module rtc_ctl_regs
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEC_W  = 20,
  parameter int TRIM_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output ctrl_t              ctrl,
  output logic [SEC_W-1:0]   alarm,
  output logic [TRIM_W-1:0]  trim,
  output logic [N_ALARM-1:0] clr
);
  localparam int HI_W = SEC_W - DATA_W;

  ctrl_t             ctrl_q, ctrl_d;
  logic [DATA_W-1:0] alo_q;
  logic [HI_W-1:0]   ahi_q;
  logic [TRIM_W-1:0] trim_q;
  logic              ctrl_we, alo_we, ahi_we, trim_we;

  always_comb begin
    ctrl_we = wr_en && (wr_addr == A_CTRL);
    alo_we  = wr_en && (wr_addr == A_ALM_LO);
    ahi_we  = wr_en && (wr_addr == A_ALM_HI);
    trim_we = wr_en && (wr_addr == A_TRIM) && ctrl_q.unlock;

    ctrl_d         = ctrl_q;
    ctrl_d.tod_ie  = wr_data[B_TOD_IE];
    ctrl_d.sub_ie  = wr_data[B_SUB_IE];
    ctrl_d.sq_en   = wr_data[B_SQ_EN];
    ctrl_d.sq_fast = wr_data[B_SQ_FAST];
    ctrl_d.unlock  = wr_data[B_UNLOCK];
    if (ctrl_q.unlock) begin
      ctrl_d.run = wr_data[B_RUN];
    end

    clr          = '0;
    clr[IDX_TOD] = ctrl_we && wr_data[B_CLR_TOD];
    clr[IDX_SUB] = ctrl_we && wr_data[B_CLR_SUB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alo_q <= '0;
    end else if (alo_we) begin
      alo_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ahi_q <= '0;
    end else if (ahi_we) begin
      ahi_q <= wr_data[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q <= '0;
    end else if (trim_we) begin
      trim_q <= wr_data[TRIM_W-1:0];
    end
  end

  assign ctrl  = ctrl_q;
  assign alarm = {ahi_q, alo_q};
  assign trim  = trim_q;
endmodule

// File: rtl/rtc_alarm_flags.sv
`timescale 1ns/1ps
module rtc_alarm_flags
  import rtc_alarm_pkg::*;
#(
  parameter int SEC_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEC_W-1:0]   sec_count,
  input  logic [SEC_W-1:0]   alarm,
  input  logic               subsec_reload,
  input  logic [N_ALARM-1:0] clr,
  output logic [N_ALARM-1:0] flags,
  output logic [N_ALARM-1:0] set_vec
);
  logic match, match_q;

  always_comb begin
    match            = (sec_count == alarm);
    set_vec          = '0;
    set_vec[IDX_TOD] = match && !match_q;
    set_vec[IDX_SUB] = subsec_reload;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
    end else begin
      match_q <= match;
    end
  end

  for (genvar g = 0; g < N_ALARM; g++) begin : g_flag
    logic flag_q, flag_d, flag_en;

    always_comb begin
      flag_en = set_vec[g] || clr[g];
      flag_d  = set_vec[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
      end else if (flag_en) begin
        flag_q <= flag_d;
      end
    end

    assign flags[g] = flag_q;
  end
endmodule

// File: rtl/rtc_sqw_mux.sv
`timescale 1ns/1ps
module rtc_sqw_mux
  import rtc_alarm_pkg::*;
(
  input  logic       sq_en,
  input  logic       sq_fast,
  input  logic       tap_slow,
  input  logic       tap_fast,
  input  logic       dbg_en,
  output logic       sqw_out,
  output logic       sqw_oe,
  output logic [1:0] pin_sel
);
  pin_sel_e owner;

  always_comb begin
    sqw_oe  = sq_en;
    sqw_out = sq_en && (sq_fast ? tap_fast : tap_slow);
    if (sq_en) begin
      owner = PIN_SQW;
    end else if (dbg_en) begin
      owner = PIN_DBG;
    end else begin
      owner = PIN_GPIO;
    end
    pin_sel = owner;
  end
endmodule

// File: rtl/rtc_alarm_ctl.sv
`timescale 1ns/1ps
module rtc_alarm_ctl
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEC_W  = 20,
  parameter int TRIM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEC_W-1:0]  sec_count,
  input  logic              subsec_reload,
  input  logic              tap_slow,
  input  logic              tap_fast,
  input  logic              dbg_en,
  input  logic              gie,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tod_flag,
  output logic              sub_flag,
  output logic              irq,
  output logic              wake,
  output logic              sqw_out,
  output logic              sqw_oe,
  output logic [1:0]        pin_sel,
  output logic              run_en,
  output logic [TRIM_W-1:0] trim
);
  logic [1:0]         rst_sync;
  logic               rst_sync_n;
  ctrl_t              ctrl;
  logic [SEC_W-1:0]   alarm;
  logic [N_ALARM-1:0] clr_vec, flags, set_vec, ie_vec, masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync[1];

  rtc_ctl_regs #(.DATA_W(DATA_W), .SEC_W(SEC_W), .TRIM_W(TRIM_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl    (ctrl),
    .alarm   (alarm),
    .trim    (trim),
    .clr     (clr_vec)
  );

  rtc_alarm_flags #(.SEC_W(SEC_W)) u_flags (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .sec_count     (sec_count),
    .alarm         (alarm),
    .subsec_reload (subsec_reload),
    .clr           (clr_vec),
    .flags         (flags),
    .set_vec       (set_vec)
  );

  rtc_sqw_mux u_sqw (
    .sq_en    (ctrl.sq_en),
    .sq_fast  (ctrl.sq_fast),
    .tap_slow (tap_slow),
    .tap_fast (tap_fast),
    .dbg_en   (dbg_en),
    .sqw_out  (sqw_out),
    .sqw_oe   (sqw_oe),
    .pin_sel  (pin_sel)
  );

  always_comb begin
    ie_vec          = '0;
    ie_vec[IDX_TOD] = ctrl.tod_ie;
    ie_vec[IDX_SUB] = ctrl.sub_ie;
    masked          = flags & ie_vec;
    wake            = |masked;
    irq             = gie && wake;
  end

  assign tod_flag = flags[IDX_TOD];
  assign sub_flag = flags[IDX_SUB];
  assign run_en   = ctrl.run;
endmodule

// File: rtl/rtc_alarm_ctl_chk.sv
`timescale 1ns/1ps
module rtc_alarm_ctl_chk #(
  parameter int TRIM_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tod_entry,
  input logic              subsec_reload,
  input logic              clr_tod,
  input logic              clr_sub,
  input logic              tod_flag,
  input logic              sub_flag,
  input logic              gie,
  input logic              irq,
  input logic              wake,
  input logic              tod_ie,
  input logic              sub_ie,
  input logic              unlock,
  input logic              sqw_out,
  input logic              sqw_oe,
  input logic [1:0]        pin_sel,
  input logic              run_en,
  input logic [TRIM_W-1:0] trim
);
  AST_TOD_ENTRY_SETS: assert property (@(posedge clk) disable iff (!rst_n) tod_entry |=> tod_flag); // R1
  AST_TOD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) (!tod_flag && !tod_entry) |=> !tod_flag); // R1
  AST_SUB_RELOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n) subsec_reload |=> sub_flag); // R2
  AST_TOD_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (tod_flag && !clr_tod) |=> tod_flag); // R3
  AST_SUB_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (sub_flag && !clr_sub) |=> sub_flag); // R3
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (subsec_reload && clr_sub) |=> sub_flag); // R4
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> gie); // R5
  AST_WAKE_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (!tod_ie && !sub_ie) |-> !wake); // R6
  AST_SQW_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !sqw_oe |-> !sqw_out); // R7
  AST_PIN_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n) sqw_oe |-> (pin_sel == 2'b10)); // R8
  AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !unlock |=> ($stable(run_en) && $stable(trim))); // R9
endmodule

bind rtc_alarm_ctl rtc_alarm_ctl_chk #(.TRIM_W(TRIM_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .tod_entry     (set_vec[0]),
  .subsec_reload (subsec_reload),
  .clr_tod       (clr_vec[0]),
  .clr_sub       (clr_vec[1]),
  .tod_flag      (tod_flag),
  .sub_flag      (sub_flag),
  .gie           (gie),
  .irq           (irq),
  .wake          (wake),
  .tod_ie        (ctrl.tod_ie),
  .sub_ie        (ctrl.sub_ie),
  .unlock        (ctrl.unlock),
  .sqw_out       (sqw_out),
  .sqw_oe        (sqw_oe),
  .pin_sel       (pin_sel),
  .run_en        (run_en),
  .trim          (trim)
);

// File: tb/rtc_alarm_ctl_bench.sv
`timescale 1ns/1ps
module rtc_alarm_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] sec_count;
  logic        subsec_reload, tap_slow, tap_fast, dbg_en, gie, wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic        tod_flag, sub_flag, irq, wake, sqw_out, sqw_oe, run_en;
  logic [1:0]  pin_sel;
  logic [7:0]  trim;

  int n_chk = 0;
  int n_fail = 0;

  // bench model state
  logic m_tod_ie, m_sub_ie, m_sq_en, m_sq_fast, m_unlock, m_run;
  logic [19:0] m_alarm;
  logic [7:0]  m_trim;
  logic m_tod, m_sub, m_match_q;

  always #2 clk = ~clk;

  rtc_alarm_ctl u_rtc_alarm_ctl (
    .clk(clk), .rst_n(rst_n), .sec_count(sec_count), .subsec_reload(subsec_reload),
    .tap_slow(tap_slow), .tap_fast(tap_fast), .dbg_en(dbg_en), .gie(gie),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tod_flag(tod_flag), .sub_flag(sub_flag), .irq(irq), .wake(wake),
    .sqw_out(sqw_out), .sqw_oe(sqw_oe), .pin_sel(pin_sel), .run_en(run_en), .trim(trim)
  );

  function automatic logic exp_wake();
    return (m_tod && m_tod_ie) || (m_sub && m_sub_ie);
  endfunction

  function automatic logic exp_irq(input logic g);
    return g && exp_wake();
  endfunction

  function automatic logic exp_sqw(input logic ts, input logic tf);
    return m_sq_en && (m_sq_fast ? tf : ts);
  endfunction

  function automatic logic [1:0] exp_pin(input logic d);
    if (m_sq_en) return 2'b10;
    if (d) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1", "tod_flag", 32'(tod_flag), 32'(m_tod));
    chk("R2", "sub_flag", 32'(sub_flag), 32'(m_sub));
    chk("R5", "irq", 32'(irq), 32'(exp_irq(gie)));
    chk("R6", "wake", 32'(wake), 32'(exp_wake()));
    chk("R7", "sqw_oe", 32'(sqw_oe), 32'(m_sq_en));
    chk("R7", "sqw_out", 32'(sqw_out), 32'(exp_sqw(tap_slow, tap_fast)));
    chk("R8", "pin_sel", 32'(pin_sel), 32'(exp_pin(dbg_en)));
    chk("R9", "run_en", 32'(run_en), 32'(m_run));
    chk("R9", "trim", 32'(trim), 32'(m_trim));
  endtask

  task automatic model_edge();
    logic match, clr_t, clr_s, cw, old_unlock;
    match = (sec_count == m_alarm);
    cw    = wr_en && (wr_addr == 2'd0);
    clr_t = cw && wr_data[6];
    clr_s = cw && wr_data[7];
    m_tod = (match && !m_match_q) || (m_tod && !clr_t);
    m_sub = subsec_reload || (m_sub && !clr_s);
    m_match_q = match;
    old_unlock = m_unlock;
    if (wr_en) begin
      case (wr_addr)
        2'd0: begin
          m_tod_ie = wr_data[0]; m_sub_ie = wr_data[1];
          m_sq_en = wr_data[2]; m_sq_fast = wr_data[3];
          m_unlock = wr_data[4];
          if (old_unlock) m_run = wr_data[5];
        end
        2'd1: m_alarm[15:0] = wr_data;
        2'd2: m_alarm[19:16] = wr_data[3:0];
        default: if (old_unlock) m_trim = wr_data[7:0];
      endcase
    end
  endtask

  // called at a negedge with inputs already set; returns at the next negedge
  task automatic cycle();
    #1;
    check_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; subsec_reload = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cycle();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    sec_count = 20'd1; subsec_reload = 0; tap_slow = 0; tap_fast = 0;
    dbg_en = 0; gie = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    {m_tod_ie, m_sub_ie, m_sq_en, m_sq_fast, m_unlock, m_run} = '0;
    m_alarm = '0; m_trim = '0; m_tod = 0; m_sub = 0; m_match_q = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    #1;
    chk("R10", "tod_flag", 32'(tod_flag), 0);
    chk("R10", "sub_flag", 32'(sub_flag), 0);
    chk("R10", "irq", 32'(irq), 0);
    chk("R10", "wake", 32'(wake), 0);
    chk("R10", "sqw_oe", 32'(sqw_oe), 0);
    chk("R10", "pin_sel", 32'(pin_sel), 0);
    chk("R10", "run_en", 32'(run_en), 0);
    chk("R10", "trim", 32'(trim), 0);
    @(negedge clk);

    // R9: locked writes ignored, unlock in same write does not count
    wr(2'd3, 16'h005A);
    chk("R9", "trim locked", 32'(trim), 0);
    wr(2'd0, 16'h0030);
    chk("R9", "run same-write unlock", 32'(run_en), 0);
    wr(2'd0, 16'h0030);
    chk("R9", "run unlocked", 32'(run_en), 1);
    wr(2'd3, 16'h005A);
    chk("R9", "trim unlocked", 32'(trim), 32'h5A);

    // R1: entry edge, no re-set while held equal
    wr(2'd1, 16'h0007);
    wr(2'd2, 16'h0000);
    sec_count = 20'd7;
    cycle();
    chk("R1", "tod set on entry", 32'(tod_flag), 1);
    wr(2'd0, 16'h0030);
    chk("R3", "tod kept by zero write", 32'(tod_flag), 1);
    wr(2'd0, 16'h0070);
    chk("R3", "tod cleared", 32'(tod_flag), 0);
    cycle(); cycle();
    chk("R1", "tod no re-set while equal", 32'(tod_flag), 0);
    sec_count = 20'd8; cycle();
    sec_count = 20'd7; cycle();
    chk("R1", "tod re-entry", 32'(tod_flag), 1);

    // R4: set and clear on the same edge
    subsec_reload = 1'b1;
    wr(2'd0, 16'h00B0);
    subsec_reload = 1'b0;
    chk("R4", "sub set beats clear", 32'(sub_flag), 1);

    // R7: disabled wave ignores fast select
    wr(2'd0, 16'h0038 & 16'hFFFB);
    tap_fast = 1'b1; tap_slow = 1'b1; dbg_en = 1'b1;
    #1;
    chk("R7", "sqw_out disabled", 32'(sqw_out), 0);
    chk("R8", "pin debug", 32'(pin_sel), 32'h1);
    @(negedge clk);
    wr(2'd0, 16'h003C);
    tap_fast = 1'b0;
    #1;
    chk("R7", "sqw_out fast tap", 32'(sqw_out), 0);
    chk("R8", "pin sqw priority", 32'(pin_sel), 32'h2);
    @(negedge clk);

    // constrained random
    wr(2'd1, 16'h0002);
    for (int i = 0; i < 4000; i++) begin
      sec_count     = 20'($urandom_range(0, 3));
      subsec_reload = ($urandom_range(0, 7) == 0);
      tap_slow      = 1'($urandom);
      tap_fast      = 1'($urandom);
      dbg_en        = 1'($urandom);
      gie           = 1'($urandom);
      wr_en         = ($urandom_range(0, 3) == 0);
      wr_addr       = 2'($urandom);
      wr_data       = 16'($urandom);
      if (wr_addr == 2'd2) wr_data[3:0] = 4'd0;
      if (wr_addr == 2'd1) wr_data = 16'($urandom_range(0, 3));
      cycle();
    end
    idle_inputs();
    cycle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule